// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides a fast clock by a programmable ratio of P×N + A. A main counter of N prescaler periods and a swallow counter of A prescaler periods steer a dual-modulus prescaler. The prescaler is modelled inside the block as a counter that divides by P+1 while the swallow count is non-zero and by P after that. P is 8 or 16, chosen by one select bit. Each full division cycle ends with a single-clock pulse for a phase comparator. The modulus-control level is also brought out.

The N, A and modulus-select inputs are checked on every clock. A setting with N below 3, or with A not smaller than N, raises an error flag and is never adopted. A legal setting is taken over only where one division cycle ends and the next begins, so a cycle in progress always completes with the values it started with. After reset the divider runs with N = 3, A = 0 and P = 8.

Top module: `swallow_divider`

## Requirements
- R1: The spacing between consecutive rising edges of pulse_o is P×N + A clocks of clk_i. P = 8 when p16_sel_i = 0 and P = 16 when p16_sel_i = 1.
- R2: mod_o is high for exactly (P+1)×A clocks of each division cycle. Those clocks are the first A prescaler periods of the cycle. mod_o is low for the rest of the cycle and changes only on a prescaler period boundary.
- R3: pulse_o is high for exactly one clk_i cycle per division cycle. It rises one clock after the edge that ends the cycle.
- R4: A change on n_cfg_i, a_cfg_i or p16_sel_i does not alter the cycle in progress. A legal setting present at the cycle-ending edge governs the next cycle.
- R5: cfg_err_o is high one clock after the inputs hold a setting with n_cfg_i < 3 or a_cfg_i >= n_cfg_i. It is low one clock after a legal setting.
- R6: An illegal setting is ignored. The divider keeps running with the last legal N, A and P.
- R7: While rst_ni is low, pulse_o, mod_o and cfg_err_o are 0. After reset the first period is 24 clocks (N = 3, A = 0, P = 8), whatever the inputs hold.
- R8: The range limits N = 3 and N = 2047 with A = 127 divide correctly. A = N−1 also divides correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Prescaler-domain input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| n_cfg_i | input | 11 | Main counter setting N |
| a_cfg_i | input | 7 | Swallow counter setting A |
| p16_sel_i | input | 1 | Prescaler modulus select: 0 gives 8/9, 1 gives 16/17 |
| mod_o | output | 1 | Modulus control: 1 makes the prescaler divide by P+1 |
| pulse_o | output | 1 | One-clock pulse at the end of each division cycle |
| cfg_err_o | output | 1 | Registered flag for an illegal setting on the inputs |

## Verification
pulse_o rises one clock after the edge that ends a cycle. The bench treats the negedge on which pulse_o reads high as the first clock of the next cycle. From there it counts negedges up to the next high pulse, and it accumulates mod_o over the same window. A setting driven on a negedge is adopted at the next cycle-ending edge, so the period and the mod_o count are checked on the cycle that follows the next pulse. cfg_err_o is registered, so the bench samples it on the first negedge after the inputs change.

// File: rtl/swallow_pkg.sv
package swallow_pkg;
  localparam int unsigned N_W   = 11;
  localparam int unsigned A_W   = 7;
  localparam int unsigned N_MIN = 3;
  localparam int unsigned N_MAX = 2047;
  localparam int unsigned P_LO  = 8;
  localparam int unsigned P_HI  = 16;
  localparam int unsigned N_DEF = 3;
  localparam int unsigned A_DEF = 0;

  typedef struct packed {
    logic [N_W-1:0] n;
    logic [A_W-1:0] a;
    logic           p16;
  } div_cfg_t;
endpackage

// File: rtl/swallow_cfg_gate.sv
module swallow_cfg_gate
  import swallow_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  div_cfg_t cfg_i,
  input  logic     load_i,
  output logic     valid_o,
  output div_cfg_t next_o,
  output div_cfg_t act_o
);
  logic n_lo_ok, n_hi_ok, a_ok;

  assign n_lo_ok = (cfg_i.n >= N_W'(N_MIN));
  assign a_ok    = ({{(N_W-A_W){1'b0}}, cfg_i.a} < cfg_i.n);

  generate
    if (N_MAX < (2**N_W) - 1) begin : g_upper
      assign n_hi_ok = (cfg_i.n <= N_W'(N_MAX));
    end else begin : g_full
      assign n_hi_ok = 1'b1;
    end
  endgenerate

  assign valid_o = n_lo_ok & n_hi_ok & a_ok;
  assign next_o  = valid_o ? cfg_i : act_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o.n   <= N_W'(N_DEF);
      act_o.a   <= A_W'(A_DEF);
      act_o.p16 <= 1'b0;
    end else if (load_i) begin
      act_o <= next_o;
    end
  end
endmodule

// File: rtl/swallow_prescaler.sv
module swallow_prescaler #(
  parameter int unsigned P_LO = 8,
  parameter int unsigned P_HI = 16,
  localparam int unsigned PC_W = $clog2(P_HI + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic p16_i,
  input  logic mod_i,
  output logic tick_o
);
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] base;
  logic [PC_W-1:0] top_val;

  assign base    = p16_i ? PC_W'(P_HI) : PC_W'(P_LO);
  // last count of this prescaler period: P-1 or P
  assign top_val = mod_i ? base : base - PC_W'(1);
  assign tick_o  = (pc_q == top_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (tick_o) pc_q <= '0;
    else             pc_q <= pc_q + PC_W'(1);
  end
endmodule

// File: rtl/swallow_counters.sv
module swallow_counters #(
  parameter int unsigned N_W   = 11,
  parameter int unsigned A_W   = 7,
  parameter int unsigned N_DEF = 3,
  parameter int unsigned A_DEF = 0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic [N_W-1:0] n_load_i,
  input  logic [A_W-1:0] a_load_i,
  output logic           last_o,
  output logic           mod_o
);
  logic [N_W-1:0] n_cnt_q;
  logic [A_W-1:0] a_cnt_q;

  assign last_o = (n_cnt_q == N_W'(1));
  assign mod_o  = (a_cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_cnt_q <= N_W'(N_DEF);
      a_cnt_q <= A_W'(A_DEF);
    end else if (tick_i) begin
      if (last_o) begin
        n_cnt_q <= n_load_i;
        a_cnt_q <= a_load_i;
      end else begin
        n_cnt_q <= n_cnt_q - N_W'(1);
        if (mod_o) a_cnt_q <= a_cnt_q - A_W'(1);
      end
    end
  end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swallow_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_W-1:0] n_cfg_i,
  input  logic [A_W-1:0] a_cfg_i,
  input  logic           p16_sel_i,
  output logic           mod_o,
  output logic           pulse_o,
  output logic           cfg_err_o
);
  div_cfg_t cfg_in, cfg_next, cfg_act;
  logic     cfg_ok, tick_w, last_w, load_w, mod_w;
  logic     pulse_q, err_q;

  assign cfg_in.n   = n_cfg_i;
  assign cfg_in.a   = a_cfg_i;
  assign cfg_in.p16 = p16_sel_i;
  assign load_w     = tick_w & last_w;

  swallow_cfg_gate u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg_in),
    .load_i (load_w),
    .valid_o(cfg_ok),
    .next_o (cfg_next),
    .act_o  (cfg_act)
  );

  swallow_prescaler #(.P_LO(P_LO), .P_HI(P_HI)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .p16_i (cfg_act.p16),
    .mod_i (mod_w),
    .tick_o(tick_w)
  );

  swallow_counters #(.N_W(N_W), .A_W(A_W), .N_DEF(N_DEF), .A_DEF(A_DEF)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_w),
    .n_load_i(cfg_next.n),
    .a_load_i(cfg_next.a),
    .last_o  (last_w),
    .mod_o   (mod_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      pulse_q <= load_w;
      err_q   <= ~cfg_ok;
    end
  end

  assign mod_o     = mod_w;
  assign pulse_o   = pulse_q;
  assign cfg_err_o = err_q;
endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk
  import swallow_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic [N_W-1:0] n_cfg_i,
  input logic [A_W-1:0] a_cfg_i,
  input logic           mod_o,
  input logic           pulse_o,
  input logic           cfg_err_o,
  input logic           tick_i,
  input logic           last_i,
  input logic           load_i,
  input logic [N_W-1:0] n_act_i,
  input logic [A_W-1:0] a_act_i
);
  // R3
  pulse_one_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  // R2
  mod_on_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> $stable(mod_o));

  // R2
  mod_off_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_i |-> !mod_o);

  // R4
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> ($stable(n_act_i) && $stable(a_act_i)));

  // R5
  err_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (cfg_err_o ==
      $past((n_cfg_i < N_W'(N_MIN)) || ({{(N_W-A_W){1'b0}}, a_cfg_i} >= n_cfg_i))));

  // R6
  always @(posedge clk_i) begin
    if (rst_ni) begin
      act_legal_chk: assert (n_act_i >= N_W'(N_MIN) &&
                             {{(N_W-A_W){1'b0}}, a_act_i} < n_act_i);
    end
  end
endmodule

bind swallow_divider swallow_divider_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .n_cfg_i  (n_cfg_i),
  .a_cfg_i  (a_cfg_i),
  .mod_o    (mod_o),
  .pulse_o  (pulse_o),
  .cfg_err_o(cfg_err_o),
  .tick_i   (tick_w),
  .last_i   (last_w),
  .load_i   (load_w),
  .n_act_i  (cfg_act.n),
  .a_act_i  (cfg_act.a)
);

// File: tb/swallow_divider_tb_top.sv
`timescale 1ns/1ps
module swallow_divider_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [10:0] n_cfg_i = 11'd10;
  logic [6:0]  a_cfg_i = 7'd5;
  logic        p16_sel_i = 1'b1;
  logic        mod_o, pulse_o, cfg_err_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  // {n, a, p16, expected period}
  localparam logic [34:0] VEC [7] = '{
    {11'd3,    7'd0,   1'b0, 16'd24},
    {11'd3,    7'd2,   1'b0, 16'd26},
    {11'd17,   7'd0,   1'b1, 16'd272},
    {11'd10,   7'd9,   1'b1, 16'd169},
    {11'd100,  7'd99,  1'b0, 16'd899},
    {11'd5,    7'd4,   1'b1, 16'd84},
    {11'd2047, 7'd127, 1'b1, 16'd32879}
  };

  always #10 clk_i = ~clk_i;

  swallow_divider dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .n_cfg_i  (n_cfg_i),
    .a_cfg_i  (a_cfg_i),
    .p16_sel_i(p16_sel_i),
    .mod_o    (mod_o),
    .pulse_o  (pulse_o),
    .cfg_err_o(cfg_err_o)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [10:0] n, input logic [6:0] a, input logic p);
    n_cfg_i = n; a_cfg_i = a; p16_sel_i = p;
  endtask

  task automatic wait_pulse();
    int k = 0;
    do begin @(negedge clk_i); k++; end while (!pulse_o && k < 40000);
  endtask

  // called on a negedge with pulse_o high; counts clocks to the next pulse
  task automatic measure(input int chg_at, input logic [10:0] cn, input logic [6:0] ca,
                         input logic cp, output int per, output int modc);
    per = 0; modc = 0;
    do begin
      modc += int'(mod_o);
      per++;
      @(negedge clk_i);
      if (per == 1) chk(!pulse_o, "R3 pulse width", int'(pulse_o), 0);
      if (per == chg_at) set_cfg(cn, ca, cp);
    end while (!pulse_o && per < 40000);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 190000);
      summary();
      $finish;
    end
  end

  initial begin
    int per, modc, k, pp;
    repeat (3) @(negedge clk_i);
    // R7 reset state
    chk(!pulse_o, "R7 pulse in reset", int'(pulse_o), 0);
    chk(!mod_o, "R7 mod in reset", int'(mod_o), 0);
    chk(!cfg_err_o, "R7 err in reset", int'(cfg_err_o), 0);
    rst_ni = 1'b1;
    k = 0;
    do begin @(negedge clk_i); k++; end while (!pulse_o && k < 1000);
    chk(k == 24, "R7 first period default", k, 24);
    measure(0, 0, 0, 0, per, modc);
    chk(per == 165, "R4 inputs adopted at boundary", per, 165);
    chk(modc == 85, "R2 mod count 10/5/16", modc, 85);

    // R1 R2 R8 vector table
    foreach (VEC[i]) begin
      set_cfg(VEC[i][34:24], VEC[i][23:17], VEC[i][16]);
      wait_pulse();
      measure(0, 0, 0, 0, per, modc);
      pp = VEC[i][16] ? 16 : 8;
      chk(per == int'(VEC[i][15:0]), "R1 R8 period", per, int'(VEC[i][15:0]));
      chk(modc == (pp + 1) * int'(VEC[i][23:17]), "R2 mod clocks", modc,
          (pp + 1) * int'(VEC[i][23:17]));
      chk(!cfg_err_o, "R5 no err on legal", int'(cfg_err_o), 0);
    end

    // R4 mid-cycle change leaves current cycle alone
    set_cfg(11'd100, 7'd99, 1'b0);
    wait_pulse();
    measure(50, 11'd3, 7'd0, 1'b1, per, modc);
    chk(per == 899, "R4 cycle unaffected by change", per, 899);
    measure(0, 0, 0, 0, per, modc);
    chk(per == 48, "R4 change takes next cycle", per, 48);

    set_cfg(11'd5, 7'd4, 1'b1);
    wait_pulse();
    measure(0, 0, 0, 0, per, modc);
    chk(per == 84, "R1 period 5/4/16", per, 84);

    // R5 R6 illegal settings
    set_cfg(11'd2, 7'd0, 1'b0);
    @(negedge clk_i);
    chk(cfg_err_o, "R5 err N below min", int'(cfg_err_o), 1);
    wait_pulse();
    measure(0, 0, 0, 0, per, modc);
    chk(per == 84, "R6 illegal N ignored", per, 84);
    chk(cfg_err_o, "R5 err held", int'(cfg_err_o), 1);

    set_cfg(11'd6, 7'd6, 1'b0);
    @(negedge clk_i);
    chk(cfg_err_o, "R5 err A equals N", int'(cfg_err_o), 1);
    wait_pulse();
    measure(0, 0, 0, 0, per, modc);
    chk(per == 84, "R6 A==N ignored", per, 84);
    chk(modc == 68, "R6 mod count kept", modc, 68);

    set_cfg(11'd0, 7'd0, 1'b1);
    @(negedge clk_i);
    chk(cfg_err_o, "R5 err N zero", int'(cfg_err_o), 1);
    wait_pulse();
    measure(0, 0, 0, 0, per, modc);
    chk(per == 84, "R6 N zero ignored", per, 84);

    set_cfg(11'd3, 7'd2, 1'b0);
    @(negedge clk_i);
    chk(!cfg_err_o, "R5 err clears", int'(cfg_err_o), 0);
    wait_pulse();
    measure(0, 0, 0, 0, per, modc);
    chk(per == 26, "R8 A=N-1 at N min", per, 26);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule